// File: doc/BRIEF.md
# PI Phase Loop Controller

This block closes a digital phase-tracking loop in fixed point. Each time a phase measurement arrives, it forms an error by subtracting its own running estimate of where the actuator has moved the phase. That estimate is the sum of a plant accumulator and an optional mirror accumulator. Proportional and integral gains are applied as arithmetic right shifts, and the block registers a signed control word for a downstream ±1 modulator.

The modulator's decisions come back on a separate strobe. Each up or down decision moves the plant accumulator by a configurable plant gain. When mirroring is on, each decision also moves the mirror accumulator by a configurable mirror gain. Every accumulator and arithmetic result saturates at the limits of the signed data width (48 bits by default, 16 of them fractional) and never wraps. The gain shifts, the integral and mirror enables and the two step gains are static configuration inputs. The step gains must lie in 0 to 2^47−1.

Top module: `pi_loop_ctrl`

## Requirements
- R1: A synchronous reset clears the plant, mirror and integral accumulators and the control output, and holds ctrlValid low.
- R2: The error is phaseIn minus the sum of the plant and mirror accumulators, saturated to the signed data range.
- R3: The proportional term is the error arithmetically shifted right by propShift (0..15), so the sign is preserved.
- R4: ctrlValid is high exactly in the cycle after a cycle with sampleValid high, and ctrlOut carries the new control word from that cycle.
- R5: ctrlOut holds its value in every cycle that does not follow a sampleValid strobe.
- R6: On modValid with mirrorEnable high, the mirror accumulator adds mirrorGain when modUp is 1 and subtracts it when modUp is 0. While mirrorEnable is low, the mirror accumulator is zero and adds nothing to the error.
- R7: With intEnable high, each sample adds the error shifted right arithmetically by intShift to the integral accumulator. The control word is the saturated sum of the proportional term and the updated integral accumulator. While intEnable is low, the integral accumulator is zero and adds nothing.
- R8: On modValid, the plant accumulator adds plantGain when modUp is 1 and subtracts it when modUp is 0. Without modValid it holds its value.
- R9: Every accumulator and the control word clamp to the range −2^47 to 2^47−1 instead of wrapping.
- R10: When sampleValid and modValid are high in the same cycle, the error uses the accumulator values from before that cycle's modulator step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | One-cycle strobe qualifying phaseIn |
| phaseIn | input | 48 | Signed phase measurement |
| modValid | input | 1 | One-cycle strobe for a modulator decision |
| modUp | input | 1 | Decision sign: 1 for +1, 0 for −1 |
| propShift | input | 4 | Proportional right-shift amount |
| intShift | input | 4 | Integral right-shift amount |
| intEnable | input | 1 | Integral path enable |
| mirrorEnable | input | 1 | Mirror accumulator enable |
| plantGain | input | 48 | Plant step per decision, 0..2^47−1 |
| mirrorGain | input | 48 | Mirror step per decision, 0..2^47−1 |
| ctrlOut | output | 48 | Registered signed control word |
| ctrlValid | output | 1 | High in the cycle ctrlOut is refreshed |

## Verification
The main sweep runs every proportional shift against several integral shifts and all four enable combinations. Random bursts of up and down decisions come before each pair of signed samples. This separates arithmetic from logical shifting, catches a mirror term that leaks in while disabled, and catches an integral term that persists after it is disabled. Directed runs push the plant and integral accumulators past both rails, where a wrapping sum produces a result with the wrong sign. Samples that arrive in the same cycle as a decision separate pre-update estimates from post-update ones.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;
  localparam int DEF_DATA_W  = 48;
  localparam int DEF_SHIFT_W = 4;

  typedef struct packed {
    logic takeSample;
    logic stepUp;
    logic stepDn;
    logic clrInt;
    logic clrMirror;
  } loop_stb_t;
endpackage

// File: rtl/pi_loop_ctl.sv
module pi_loop_ctl
  import pi_loop_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleValid,
  input  logic      modValid,
  input  logic      modUp,
  input  logic      intEnable,
  input  logic      mirrorEnable,
  output loop_stb_t stb,
  output logic      ctrlValid
);
  always_comb begin
    stb.takeSample = sampleValid;
    stb.stepUp     = modValid & modUp;
    stb.stepDn     = modValid & ~modUp;
    stb.clrInt     = ~intEnable;
    stb.clrMirror  = ~mirrorEnable;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrlValid <= 1'b0;
    else     ctrlValid <= sampleValid;
  end
endmodule

// File: rtl/pi_loop_dp.sv
module pi_loop_dp
  import pi_loop_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int SHIFT_W = DEF_SHIFT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  loop_stb_t                 stb,
  input  logic signed [DATA_W-1:0]  phaseIn,
  input  logic        [SHIFT_W-1:0] propShift,
  input  logic        [SHIFT_W-1:0] intShift,
  input  logic signed [DATA_W-1:0]  plantGain,
  input  logic signed [DATA_W-1:0]  mirrorGain,
  output logic signed [DATA_W-1:0]  ctrlOut
);
  localparam int WW = DATA_W + 2;
  localparam logic signed [WW-1:0] HI = {3'b000, {(DATA_W-1){1'b1}}};
  localparam logic signed [WW-1:0] LO = {3'b111, {(DATA_W-1){1'b0}}};

  function automatic logic signed [WW-1:0] widen(input logic signed [DATA_W-1:0] x);
    return {{2{x[DATA_W-1]}}, x};
  endfunction

  function automatic logic signed [DATA_W-1:0] clamp(input logic signed [WW-1:0] v);
    if (v > HI)      return HI[DATA_W-1:0];
    else if (v < LO) return LO[DATA_W-1:0];
    else             return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] plantAcc, mirrorAcc, intAcc;
  logic signed [DATA_W-1:0] err, propTerm, intTerm, intNext, intUse, ctrlNext;
  logic signed [DATA_W-1:0] plantUp, plantDn, mirrorUp, mirrorDn;

  always_comb begin
    err      = clamp(widen(phaseIn) - (widen(plantAcc) + widen(mirrorAcc)));
    propTerm = err >>> propShift;
    intTerm  = err >>> intShift;
    intNext  = clamp(widen(intAcc) + widen(intTerm));
    intUse   = stb.clrInt ? '0 : intNext;
    ctrlNext = clamp(widen(propTerm) + widen(intUse));
    plantUp  = clamp(widen(plantAcc) + widen(plantGain));
    plantDn  = clamp(widen(plantAcc) - widen(plantGain));
    mirrorUp = clamp(widen(mirrorAcc) + widen(mirrorGain));
    mirrorDn = clamp(widen(mirrorAcc) - widen(mirrorGain));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plantAcc  <= '0;
      mirrorAcc <= '0;
      intAcc    <= '0;
      ctrlOut   <= '0;
    end else begin
      if (stb.takeSample) ctrlOut <= ctrlNext;

      if (stb.clrInt)          intAcc <= '0;
      else if (stb.takeSample) intAcc <= intNext;

      if (stb.stepUp)      plantAcc <= plantUp;
      else if (stb.stepDn) plantAcc <= plantDn;

      if (stb.clrMirror)   mirrorAcc <= '0;
      else if (stb.stepUp) mirrorAcc <= mirrorUp;
      else if (stb.stepDn) mirrorAcc <= mirrorDn;
    end
  end
endmodule

// File: rtl/pi_loop_ctrl.sv
module pi_loop_ctrl
  import pi_loop_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int SHIFT_W = DEF_SHIFT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sampleValid,
  input  logic signed [DATA_W-1:0]  phaseIn,
  input  logic                      modValid,
  input  logic                      modUp,
  input  logic        [SHIFT_W-1:0] propShift,
  input  logic        [SHIFT_W-1:0] intShift,
  input  logic                      intEnable,
  input  logic                      mirrorEnable,
  input  logic signed [DATA_W-1:0]  plantGain,
  input  logic signed [DATA_W-1:0]  mirrorGain,
  output logic signed [DATA_W-1:0]  ctrlOut,
  output logic                      ctrlValid
);
  loop_stb_t stb;

  pi_loop_ctl uCtl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .modValid(modValid),
    .modUp(modUp), .intEnable(intEnable), .mirrorEnable(mirrorEnable),
    .stb(stb), .ctrlValid(ctrlValid)
  );

  pi_loop_dp #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .phaseIn(phaseIn),
    .propShift(propShift), .intShift(intShift),
    .plantGain(plantGain), .mirrorGain(mirrorGain), .ctrlOut(ctrlOut)
  );
endmodule

// File: rtl/pi_loop_chk.sv
module pi_loop_chk #(
  parameter int DATA_W = 48
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sampleValid,
  input logic                     modValid,
  input logic                     modUp,
  input logic                     intEnable,
  input logic                     mirrorEnable,
  input logic                     ctrlValid,
  input logic signed [DATA_W-1:0] ctrlOut,
  input logic signed [DATA_W-1:0] plantGain,
  input logic signed [DATA_W-1:0] plantAcc,
  input logic signed [DATA_W-1:0] mirrorAcc,
  input logic signed [DATA_W-1:0] intAcc
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> ctrlValid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> !ctrlValid);
  a_r5_output_hold: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(ctrlOut));
  a_r6_mirror_zero: assert property (@(posedge clk) disable iff (rst)
    !mirrorEnable |=> mirrorAcc == '0);
  a_r7_int_zero: assert property (@(posedge clk) disable iff (rst)
    !intEnable |=> intAcc == '0);
  a_r8_plant_hold: assert property (@(posedge clk) disable iff (rst)
    !modValid |=> $stable(plantAcc));
  a_r8_plant_up: assert property (@(posedge clk) disable iff (rst)
    (modValid && modUp && plantGain >= 0) |=> plantAcc >= $past(plantAcc));
  a_r8_plant_dn: assert property (@(posedge clk) disable iff (rst)
    (modValid && !modUp && plantGain >= 0) |=> plantAcc <= $past(plantAcc));
endmodule

bind pi_loop_ctrl pi_loop_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .modValid(modValid),
  .modUp(modUp), .intEnable(intEnable), .mirrorEnable(mirrorEnable),
  .ctrlValid(ctrlValid), .ctrlOut(ctrlOut), .plantGain(plantGain),
  .plantAcc(uDp.plantAcc), .mirrorAcc(uDp.mirrorAcc), .intAcc(uDp.intAcc)
);

// File: tb/tb_pi_loop_ctrl.sv
module tb_pi_loop_ctrl;
  localparam longint MAXV = (64'sd1 <<< 47) - 1;
  localparam longint MINV = -(64'sd1 <<< 47);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0, modValid = 1'b0, modUp = 1'b0;
  logic signed [47:0] phaseIn = '0, plantGain = '0, mirrorGain = '0;
  logic [3:0] propShift = '0, intShift = '0;
  logic intEnable = 1'b0, mirrorEnable = 1'b0;
  logic signed [47:0] ctrlOut;
  logic ctrlValid;

  int nVec = 0, nBad = 0;
  longint pM = 0, mM = 0, iM = 0;

  always #4 clk = ~clk;

  pi_loop_ctrl dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .phaseIn(phaseIn),
    .modValid(modValid), .modUp(modUp), .propShift(propShift), .intShift(intShift),
    .intEnable(intEnable), .mirrorEnable(mirrorEnable), .plantGain(plantGain),
    .mirrorGain(mirrorGain), .ctrlOut(ctrlOut), .ctrlValid(ctrlValid)
  );

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelMod(bit up);
    pM = up ? sat(pM + longint'(plantGain)) : sat(pM - longint'(plantGain));
    if (mirrorEnable) mM = up ? sat(mM + longint'(mirrorGain)) : sat(mM - longint'(mirrorGain));
    else mM = 0;
  endtask

  function automatic longint modelSample(longint ph);
    longint e, p;
    e = sat(ph - (pM + mM));
    p = e >>> propShift;
    if (intEnable) iM = sat(iM + (e >>> intShift));
    else iM = 0;
    return sat(p + iM);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    pM = 0; mM = 0; iM = 0;
  endtask

  task automatic setCfg(int ps, int is, bit ie, bit me);
    @(negedge clk);
    propShift = 4'(ps); intShift = 4'(is);
    intEnable = ie; mirrorEnable = me;
    if (!ie) iM = 0;
    if (!me) mM = 0;
  endtask

  task automatic doMod(bit up);
    @(negedge clk);
    modValid = 1'b1; modUp = up;
    modelMod(up);
    @(negedge clk);
    modValid = 1'b0;
  endtask

  // withMod: a decision in the same cycle as the sample (R10)
  task automatic doSample(longint ph, bit withMod, bit up, bit chkHold, string req);
    longint exp, held;
    @(negedge clk);
    sampleValid = 1'b1; phaseIn = ph[47:0];
    exp = modelSample(ph);
    if (withMod) begin
      modValid = 1'b1; modUp = up;
      modelMod(up);
    end
    @(negedge clk);
    sampleValid = 1'b0; modValid = 1'b0;
    check(req, longint'(ctrlOut), exp);
    check("R4 ctrlValid after sample", longint'(ctrlValid), 1);
    if (chkHold) begin
      held = longint'(ctrlOut);
      phaseIn = ~phaseIn;
      @(negedge clk);
      check("R5 output held", longint'(ctrlOut), held);
      check("R4 ctrlValid low", longint'(ctrlValid), 0);
    end
  endtask

  function automatic longint rnd48();
    longint v;
    v = longint'({$urandom, $urandom});
    return (v <<< 16) >>> 16;
  endfunction

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset ctrlOut", longint'(ctrlOut), 0);
    check("R1 reset ctrlValid", longint'(ctrlValid), 0);
    // R1: zero accumulators seen through error with unity proportional path
    setCfg(0, 0, 1'b0, 1'b0);
    doSample(12345, 1'b0, 1'b0, 1'b1, "R1 accumulators clear");

    // Sweep: R2 R3 R6 R7 R8 R10 across shifts and enables
    for (int ps = 0; ps < 16; ps++) begin
      for (int k = 0; k < 4; k++) begin
        for (int en = 0; en < 4; en++) begin
          int is;
          is = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 7 : 15;
          plantGain  = 48'($urandom_range(0, 1 << 20));
          mirrorGain = 48'($urandom_range(0, 1 << 24));
          setCfg(ps, is, en[0], en[1]);
          for (int m = 0; m < int'($urandom_range(0, 4)); m++) doMod($urandom_range(0, 1) == 1);
          doSample(rnd48() >>> 8, 1'b0, 1'b0, 1'b0, "R3 R7 sweep control word");
          doSample(rnd48() >>> 8, 1'b1, $urandom_range(0, 1) == 1, ps == 5, "R10 R2 R6 sweep same-cycle step");
        end
      end
    end

    // R9 R8: plant accumulator clamps at both rails
    doReset();
    setCfg(0, 0, 1'b0, 1'b0);
    plantGain = 48'(MAXV);
    repeat (3) doMod(1'b1);
    doSample(0, 1'b0, 1'b0, 1'b0, "R9 plant clamp high");
    repeat (5) doMod(1'b0);
    doSample(0, 1'b0, 1'b0, 1'b0, "R9 plant clamp low");
    doSample(MAXV, 1'b0, 1'b0, 1'b1, "R9 R2 error clamp");

    // R9 R7: integral accumulator clamps
    doReset();
    plantGain = '0;
    setCfg(15, 0, 1'b1, 1'b0);
    repeat (3) doSample(MAXV, 1'b0, 1'b0, 1'b0, "R9 integral clamp high");
    repeat (4) doSample(MINV, 1'b0, 1'b0, 1'b0, "R9 integral clamp low");
    // R7: disabling clears the integral contribution
    setCfg(15, 0, 1'b0, 1'b0);
    doSample(64, 1'b0, 1'b0, 1'b0, "R7 integral disabled");

    // R6: mirror cleared and ignored when disabled
    doReset();
    plantGain = 48'd100; mirrorGain = 48'd5000;
    setCfg(0, 0, 1'b0, 1'b1);
    repeat (2) doMod(1'b1);
    doSample(0, 1'b0, 1'b0, 1'b0, "R6 mirror adds");
    setCfg(0, 0, 1'b0, 1'b0);
    repeat (2) doMod(1'b1);
    doSample(0, 1'b0, 1'b0, 1'b0, "R6 mirror disabled");
    // R3: negative error keeps sign under shift
    setCfg(3, 0, 1'b0, 1'b0);
    doSample(-1001, 1'b0, 1'b0, 1'b0, "R3 arithmetic shift");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule